// File: doc/BRIEF.md
# Windowed Watchdog on a Shared Timebase

This block is a watchdog that has no free-running divider of its own. Its count clock is a one-cycle tick taken from a tap of an existing timebase. Software picks one of two timebases, the main one or the sub-clock one, and picks one of `N_TAPS` taps on it. Each selected tick advances a 2-bit counter. On the fourth tick after the last kick, the counter wraps from 3 and the block raises a reset pulse that lasts a fixed number of clocks.

A kick can land anywhere inside a tick period. The reset therefore arrives between three and four tick periods after the last kick. The tap choice sets where that window sits.

Software uses a single control word. On write, the word carries enable, kick, source select, cause-clear and tap select. On read, the same word returns enable, source, tap and a cause flag. The cause flag records that the watchdog has fired. The watchdog cannot be switched off once it is enabled. Its source and tap are locked while it runs. Only a chip reset or its own expiry returns it to the disabled state.

Top module: `wdt_window`

## Requirements
- R1: After `rst_ni` is released, `ctl_rdata_o` is all zeros and `wdt_rst_o` is low.
- R2: A write with bit 0 set enables the watchdog, and readback bit 0 goes high. A write with bit 0 clear while enabled leaves it enabled.
- R3: While disabled, a write loads the source from bit 2 (0 = main, 1 = sub) and the tap from bits [4+:SEL_W]. While enabled, those write fields are ignored. Readback shows the source at bit 2 and the tap at bits [4+:SEL_W].
- R4: Only the tick at the selected tap index of the selected source advances the counter. Ticks on every other tap of both sources have no effect.
- R5: When a selected tick arrives with the counter at 3, `wdt_rst_o` rises on the following cycle. It stays high for exactly `RST_CYCLES` cycles.
- R6: A write with bit 1 (kick) set returns the counter to 0. A kick wins over a selected tick on the same edge.
- R7: When the watchdog fires, it disables itself (readback bit 0 clears) and its counter returns to 0.
- R8: Firing sets the cause flag (readback bit 3). A write with bit 3 set clears it. If a clear and a firing land on the same edge, the flag stays set.
- R9: Writes are ignored while `wdt_rst_o` is high.
- R10: While disabled, ticks do not advance the counter, so no reset is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | CTL_W | Control word write data |
| main_tick_i | input | N_TAPS | One-cycle tick pulses, one per main timebase tap |
| sub_tick_i | input | N_TAPS | One-cycle tick pulses, one per sub-clock timebase tap |
| ctl_rdata_o | output | CTL_W | Control word readback |
| wdt_rst_o | output | 1 | Watchdog reset pulse |

## Verification
The bench targets these corner cases:

- **Kick and tick on the same edge.** A design that lets the tick win fires one period early.
- **Cause clear and firing on the same edge.** A design that lets the clear win loses the record of the reset.
- **Write during the reset pulse.** A design that accepts it re-enables the watchdog, or clears the flag, while the chip is still held in reset.
- **Tap and source mismatches.** Ticks on unselected taps and on the unselected timebase show whether the mux decodes the index against the wrong source.
- **Disable write and retargeting while running.** Attempts to disable or retarget the watchdog while it runs expose a missing lock.
- **Pulse width.** The pulse is counted cycle by cycle, which catches an off-by-one in its length.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int EN_BIT    = 0;
  localparam int KICK_BIT  = 1;
  localparam int SRC_BIT   = 2;
  localparam int CAUSE_BIT = 3;
  localparam int SEL_LSB   = 4;

  typedef enum logic {
    SRC_MAIN = 1'b0,
    SRC_SUB  = 1'b1
  } wdt_src_e;

  function automatic int sel_width(int n_taps);
    return (n_taps > 1) ? $clog2(n_taps) : 1;
  endfunction
endpackage

// File: rtl/wdt_tick_sel.sv
module wdt_tick_sel
  import wdt_pkg::*;
#(
  parameter int N_TAPS = 4,
  parameter int SEL_W  = 2
) (
  input  logic [N_TAPS-1:0] main_tick_i,
  input  logic [N_TAPS-1:0] sub_tick_i,
  input  wdt_src_e          src_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              en_i,
  output logic              tick_o
);
  logic [N_TAPS-1:0] hit;

  for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
    assign hit[g] = (sel_i == SEL_W'(g)) &&
                    ((src_i == SRC_SUB) ? sub_tick_i[g] : main_tick_i[g]);
  end

  assign tick_o = en_i & (|hit);
endmodule

// File: rtl/wdt_ctl_reg.sv
module wdt_ctl_reg
  import wdt_pkg::*;
#(
  parameter int SEL_W = 2,
  parameter int CTL_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CTL_W-1:0] wdata_i,
  input  logic             fire_i,
  output logic             en_o,
  output wdt_src_e         src_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             cause_o,
  output logic             kick_o
);
  logic             en_q, cause_q;
  wdt_src_e         src_q;
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      src_q   <= SRC_MAIN;
      sel_q   <= '0;
      cause_q <= 1'b0;
    end else begin
      // enable is sticky: only expiry or chip reset clears it
      if (fire_i)                        en_q <= 1'b0;
      else if (wr_i && wdata_i[EN_BIT])  en_q <= 1'b1;
      // routing locked while running
      if (wr_i && !en_q) begin
        src_q <= wdt_src_e'(wdata_i[SRC_BIT]);
        sel_q <= wdata_i[SEL_LSB +: SEL_W];
      end
      if (fire_i)                          cause_q <= 1'b1;
      else if (wr_i && wdata_i[CAUSE_BIT]) cause_q <= 1'b0;
    end
  end

  assign en_o    = en_q;
  assign src_o   = src_q;
  assign sel_o   = sel_q;
  assign cause_o = cause_q;
  assign kick_o  = wr_i & wdata_i[KICK_BIT];
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int RST_CYCLES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       kick_i,
  output logic       fire_o,
  output logic [1:0] cnt_o,
  output logic       wdt_rst_o
);
  localparam int PW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;

  logic [1:0]    cnt_q;
  logic [PW-1:0] pcnt_q;
  logic          rst_q;

  assign fire_o = tick_i && (cnt_q == 2'd3) && !kick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pcnt_q <= '0;
      rst_q  <= 1'b0;
    end else begin
      if (fire_o || kick_i) cnt_q <= '0;
      else if (tick_i)      cnt_q <= cnt_q + 2'd1;

      if (fire_o) begin
        rst_q  <= 1'b1;
        pcnt_q <= PW'(RST_CYCLES - 1);
      end else if (rst_q) begin
        if (pcnt_q == '0) rst_q  <= 1'b0;
        else              pcnt_q <= pcnt_q - 1'b1;
      end
    end
  end

  assign cnt_o     = cnt_q;
  assign wdt_rst_o = rst_q;
endmodule

// File: rtl/wdt_window.sv
module wdt_window
  import wdt_pkg::*;
#(
  parameter int  N_TAPS     = 4,
  parameter int  RST_CYCLES = 4,
  localparam int SEL_W      = sel_width(N_TAPS),
  localparam int CTL_W      = SEL_LSB + SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_we_i,
  input  logic [CTL_W-1:0]  ctl_wdata_i,
  input  logic [N_TAPS-1:0] main_tick_i,
  input  logic [N_TAPS-1:0] sub_tick_i,
  output logic [CTL_W-1:0]  ctl_rdata_o,
  output logic              wdt_rst_o
);
  logic             wr, en, cause, kick, tick, fire;
  wdt_src_e         src;
  logic [SEL_W-1:0] sel;
  logic [1:0]       cnt_q;

  // chip held in reset: bus writes dropped
  assign wr = ctl_we_i & ~wdt_rst_o;

  wdt_ctl_reg #(.SEL_W(SEL_W), .CTL_W(CTL_W)) ctl_i (
    .clk_i, .rst_ni, .wr_i(wr), .wdata_i(ctl_wdata_i), .fire_i(fire),
    .en_o(en), .src_o(src), .sel_o(sel), .cause_o(cause), .kick_o(kick)
  );

  wdt_tick_sel #(.N_TAPS(N_TAPS), .SEL_W(SEL_W)) tsel_i (
    .main_tick_i, .sub_tick_i, .src_i(src), .sel_i(sel), .en_i(en), .tick_o(tick)
  );

  wdt_core #(.RST_CYCLES(RST_CYCLES)) core_i (
    .clk_i, .rst_ni, .tick_i(tick), .kick_i(kick),
    .fire_o(fire), .cnt_o(cnt_q), .wdt_rst_o(wdt_rst_o)
  );

  always_comb begin
    ctl_rdata_o                    = '0;
    ctl_rdata_o[EN_BIT]            = en;
    ctl_rdata_o[SRC_BIT]           = src;
    ctl_rdata_o[CAUSE_BIT]         = cause;
    ctl_rdata_o[SEL_LSB +: SEL_W]  = sel;
  end
endmodule

// File: rtl/wdt_window_chk.sv
module wdt_window_chk #(
  parameter int CTL_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CTL_W-1:0] ctl_rdata_o,
  input logic             wdt_rst_o,
  input logic [1:0]       cnt_q
);
  // R2
  en_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_rdata_o[0] |=> (ctl_rdata_o[0] || $rose(wdt_rst_o)));
  // R5
  fire_from_three_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdt_rst_o) |-> $past(cnt_q) == 2'd3);
  // R7
  fire_disables_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdt_rst_o) |-> (!ctl_rdata_o[0] && cnt_q == 2'd0));
  // R8
  cause_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdt_rst_o) |-> ctl_rdata_o[3]);
  // R9
  no_write_in_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |=> $stable(ctl_rdata_o));
  // R10
  idle_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_rdata_o[0] |-> cnt_q == 2'd0);
endmodule

bind wdt_window wdt_window_chk #(.CTL_W(CTL_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .ctl_rdata_o(ctl_rdata_o),
  .wdt_rst_o(wdt_rst_o), .cnt_q(cnt_q)
);

// File: tb/wdt_window_tb_top.sv
`timescale 1ns/1ps
module wdt_window_tb_top;
  localparam int N  = 4;
  localparam int RC = 4;
  localparam int SW = 2;
  localparam int CW = 4 + SW;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          we = 1'b0;
  logic [CW-1:0] wd = '0;
  logic [N-1:0]  mt = '0, st = '0;
  logic [CW-1:0] rdata;
  logic          wrst;

  int total = 0, bad = 0, cyc = 0;

  // reference state
  logic          m_en, m_src, m_cause, m_rst;
  logic [SW-1:0] m_sel;
  logic [1:0]    m_cnt;
  int            m_pc;

  always #2.5 clk = ~clk;

  wdt_window #(.N_TAPS(N), .RST_CYCLES(RC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ctl_we_i(we), .ctl_wdata_i(wd),
    .main_tick_i(mt), .sub_tick_i(st), .ctl_rdata_o(rdata), .wdt_rst_o(wrst)
  );

  function automatic logic [CW-1:0] exp_rdata();
    logic [CW-1:0] r = '0;
    r[0] = m_en; r[2] = m_src; r[3] = m_cause; r[4 +: SW] = m_sel;
    return r;
  endfunction

  task automatic model_reset();
    m_en = 0; m_src = 0; m_cause = 0; m_rst = 0; m_sel = '0; m_cnt = '0; m_pc = 0;
  endtask

  task automatic model_edge();
    logic tick, wr, fire;
    tick = m_en && (m_src ? st[m_sel] : mt[m_sel]);
    wr   = we && !m_rst;
    fire = tick && m_cnt == 2'd3 && !(wr && wd[1]);
    if (fire) begin m_rst = 1; m_pc = RC - 1; end
    else if (m_rst) begin if (m_pc == 0) m_rst = 0; else m_pc--; end
    if (wr && !m_en) begin m_src = wd[2]; m_sel = wd[4 +: SW]; end
    if (fire) m_en = 0; else if (wr && wd[0]) m_en = 1;
    if (fire || (wr && wd[1])) m_cnt = 0; else if (tick) m_cnt = m_cnt + 2'd1;
    if (fire) m_cause = 1; else if (wr && wd[3]) m_cause = 0;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic step(input logic w, input logic [CW-1:0] d,
                      input logic [N-1:0] m, input logic [N-1:0] s);
    @(negedge clk);
    we = w; wd = d; mt = m; st = s;
    model_edge();
    @(posedge clk); #1;
    chk(32'(wrst), 32'(m_rst), "R5 pulse");
    chk(32'(rdata), 32'(exp_rdata()), "R2 readback");
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, '0, '0, '0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R1
    chk(32'(rdata), 0, "R1 rdata");
    chk(32'(wrst), 0, "R1 rst");

    // R10: disabled, every tap ticking
    for (int i = 0; i < 10; i++) step(0, '0, '1, '1);
    chk(32'(wrst), 0, "R10");

    step(1, 6'h21, '0, '0);            // enable, main, tap 2
    chk(32'(rdata), 32'h21, "R2 enable");
    step(1, 6'h14, '0, '0);            // disable + retarget attempt
    chk(32'(rdata), 32'h21, "R3 locked");

    // R4: wrong taps / wrong source only
    for (int i = 0; i < 8; i++) step(0, '0, 4'b1011, 4'b0100);
    chk(32'(wrst), 0, "R4 wrong tap");

    for (int i = 0; i < 3; i++) step(0, '0, 4'b0100, '0);
    step(1, 6'h22, 4'b0100, '0);       // kick + tick same edge
    for (int i = 0; i < 3; i++) step(0, '0, 4'b0100, '0);
    chk(32'(wrst), 0, "R6 kick wins");
    step(0, '0, 4'b0100, '0);          // fourth tick
    chk(32'(wrst), 1, "R5 fire");
    chk(32'(rdata), 32'h28, "R7 disabled");
    step(1, 6'h09, '0, '0);            // write during pulse
    chk(32'(rdata), 32'h28, "R9 ignored");
    for (int i = 0; i < RC - 2; i++) step(0, '0, '0, '0);
    chk(32'(wrst), 1, "R5 width");
    step(0, '0, '0, '0);
    chk(32'(wrst), 0, "R5 end");
    chk(32'(rdata), 32'h28, "R9 en stays off");

    step(1, 6'h28, '0, '0);
    chk(32'(rdata), 32'h20, "R8 clear");

    step(1, 6'h21, '0, '0);
    for (int i = 0; i < 3; i++) step(0, '0, 4'b0100, '0);
    step(1, 6'h08, 4'b0100, '0);       // cause clear vs fire
    chk(32'(rdata), 32'h28, "R8 set wins");
    idle(RC + 1);

    step(1, 6'h1d, '0, '0);            // enable, sub source, tap 1, clear cause
    chk(32'(rdata), 32'h15, "R3 load");
    for (int i = 0; i < 4; i++) step(0, '0, 4'b0010, 4'b0010);
    chk(32'(wrst), 1, "R4 sub tap");
    idle(RC + 1);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic          w;
      logic [CW-1:0] d;
      logic [N-1:0]  m, s;
      w = ($urandom % 10) == 0;
      d = CW'($urandom);
      if (($urandom % 4) != 0) d[1] = 1'b0;
      m = N'($urandom) & N'($urandom);
      s = N'($urandom) & N'($urandom) & N'($urandom);
      step(w, d, m, s);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule